// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Data Register Bank

This block keeps the state of a digitally controlled potentiometer: one volatile wiper register and a small bank of persistent data registers that hold saved wiper settings. A front end that has already parsed the serial frame hands it one command at a time on a parallel command port. The block performs the command: a read, a direct write to the wiper, a copy between the wiper and a chosen data register, or a write to a data register. It also drives a one-hot tap-select vector for the resistor switch array, taken from the wiper.

The data registers stand in for slow persistent storage. A write to one of them is only held as pending while the command arrives. It is committed when the front end signals the end of the frame. The write then takes a set number of clock cycles, and a busy flag stays high for that whole time. An active-low protect input stops every data register write but leaves the wiper free. On reset release the wiper is reloaded from data register 0, and the data registers keep their contents through reset.

Top module: `pot_state_bank`

## Requirements
- R1: While rst_n is low, wip and rd_valid are 0.
- R2: On the first clock edge after reset release, the wiper takes the value of data register 0; commands presented in that cycle are ignored. Data registers keep their contents across reset.
- R3: A command with cmd_op = 1 (wiper write) loads cmd_wdata into the wiper at the next clock edge. With no command and no recall, the wiper holds.
- R4: A command with cmd_op = 4 (load wiper) copies data register cmd_sel into the wiper at the next clock edge.
- R5: A data register write is requested with cmd_op = 3 (value cmd_wdata) or cmd_op = 5 (value = wiper at the command edge). The request is only held pending; no data register changes and wip stays 0 until a frame_end pulse.
- R6: A frame_end pulse with a request pending starts the write. wip is 1 for exactly WRITE_CYCLES cycles, and the target register takes the pending value on the edge where wip falls, not before. frame_end always discards the pending request.
- R7: While wip is 1, new data register write requests are dropped and never start a write. Reads and wiper writes are still serviced.
- R8: While wp_n is 0, a data register write request is dropped, and a pending request is not started by frame_end. Wiper writes are unaffected.
- R9: Reads return on the cycle after the command, with rd_valid high for one cycle: cmd_op = 0 returns the wiper, cmd_op = 2 returns data register cmd_sel, and cmd_op = 6 returns wip in bit 0 with all other bits 0.
- R10: tap_sel has exactly one bit set, at the index equal to the wiper value; bit 0 is the low end of the array and bit TAPS-1 the high end. It follows a wiper load in the same cycle the wiper register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (0 read wiper, 1 write wiper, 2 read data reg, 3 write data reg, 4 load wiper, 5 store wiper, 6 read status) |
| cmd_sel | input | SEL_W (2) | Data register index |
| cmd_wdata | input | WIPER_W (10) | Write value |
| frame_end | input | 1 | End-of-frame pulse that commits a pending data register write |
| wp_n | input | 1 | Active-low protect for data register writes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | WIPER_W (10) | Read result |
| wip | output | 1 | Persistent write in progress |
| wiper | output | WIPER_W (10) | Current wiper position |
| tap_sel | output | TAPS (1024) | One-hot tap switch select |

## Verification
The bench builds the block with the default 10-bit wiper and four data registers, but sets WRITE_CYCLES to 20 instead of a millisecond-scale count. That short busy window lets the bench time its full length, and it leaves room to place reads, wiper writes and a competing data register write inside it. The full 1024-bit tap vector is still exercised, including both end taps.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

  typedef enum logic [2:0] {
    OP_RD_WIPER    = 3'd0,
    OP_WR_WIPER    = 3'd1,
    OP_RD_DATA     = 3'd2,
    OP_WR_DATA     = 3'd3,
    OP_LOAD_WIPER  = 3'd4,
    OP_STORE_WIPER = 3'd5,
    OP_RD_STATUS   = 3'd6,
    OP_NOP         = 3'd7
  } pot_op_e;

  typedef enum logic [1:0] {
    RSRC_WIPER  = 2'd0,
    RSRC_DATA   = 2'd1,
    RSRC_STATUS = 2'd2,
    RSRC_NONE   = 2'd3
  } rd_src_e;

  typedef struct packed {
    logic    wiper_wr;
    logic    wiper_load;
    logic    dr_req;
    logic    dr_from_wiper;
    logic    rd_en;
    rd_src_e rd_src;
  } pot_dec_t;

endpackage

// File: rtl/pot_cmd_decode.sv
module pot_cmd_decode
  import potbank_pkg::*;
(
  input  logic       valid,
  input  logic       enable,
  input  logic [2:0] op,
  output pot_dec_t   dec
);

  always_comb begin
    dec        = '0;
    dec.rd_src = RSRC_NONE;
    if (valid && enable) begin
      case (pot_op_e'(op))
        OP_RD_WIPER: begin
          dec.rd_en  = 1'b1;
          dec.rd_src = RSRC_WIPER;
        end
        OP_WR_WIPER:   dec.wiper_wr   = 1'b1;
        OP_RD_DATA: begin
          dec.rd_en  = 1'b1;
          dec.rd_src = RSRC_DATA;
        end
        OP_WR_DATA:    dec.dr_req     = 1'b1;
        OP_LOAD_WIPER: dec.wiper_load = 1'b1;
        OP_STORE_WIPER: begin
          dec.dr_req        = 1'b1;
          dec.dr_from_wiper = 1'b1;
        end
        OP_RD_STATUS: begin
          dec.rd_en  = 1'b1;
          dec.rd_src = RSRC_STATUS;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pot_nv_writer.sv
module pot_nv_writer #(
  parameter int VAL_W        = 10,
  parameter int SEL_W        = 2,
  parameter int WRITE_CYCLES = 500000,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [VAL_W-1:0] req_val,
  input  logic             frame_end,
  input  logic             wp_n,
  output logic             wip,
  output logic             commit,
  output logic [SEL_W-1:0] commit_sel,
  output logic [VAL_W-1:0] commit_val
);

  logic             pend_q, pend_d;
  logic [SEL_W-1:0] pend_sel_q;
  logic [VAL_W-1:0] pend_val_q;
  logic             pend_load;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;
  logic             last;

  logic [SEL_W-1:0] job_sel_q;
  logic [VAL_W-1:0] job_val_q;

  assign pend_load = req && wp_n && !busy_q;
  assign start     = frame_end && pend_q && wp_n && !busy_q;
  assign last      = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    pend_d = pend_q;
    if (frame_end)      pend_d = 1'b0;
    else if (pend_load) pend_d = 1'b1;

    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WRITE_CYCLES);
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_load && !frame_end) begin
      pend_sel_q <= req_sel;
      pend_val_q <= req_val;
    end
    if (start) begin
      job_sel_q <= pend_sel_q;
      job_val_q <= pend_val_q;
    end
  end

  assign wip        = busy_q;
  assign commit     = last;
  assign commit_sel = job_sel_q;
  assign commit_val = job_val_q;

endmodule

// File: rtl/pot_tap_decoder.sv
module pot_tap_decoder #(
  parameter int CODE_W = 10,
  localparam int TAPS  = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [TAPS-1:0]   tap
);

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap[i] = (code == CODE_W'(i));
  end

endmodule

// File: rtl/pot_state_bank.sv
module pot_state_bank
  import potbank_pkg::*;
#(
  parameter int WIPER_W      = 10,
  parameter int NUM_DR       = 4,
  parameter int WRITE_CYCLES = 500000,
  localparam int SEL_W       = $clog2(NUM_DR),
  localparam int TAPS        = 1 << WIPER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic [WIPER_W-1:0] cmd_wdata,
  input  logic               frame_end,
  input  logic               wp_n,
  output logic               rd_valid,
  output logic [WIPER_W-1:0] rd_data,
  output logic               wip,
  output logic [WIPER_W-1:0] wiper,
  output logic [TAPS-1:0]    tap_sel
);

  pot_dec_t dec;
  logic     recall_q;

  logic [NUM_DR-1:0][WIPER_W-1:0] dr_q;
  logic [WIPER_W-1:0] wiper_q, wiper_d;
  logic               wiper_en;

  logic               wip_w;
  logic               commit;
  logic [SEL_W-1:0]   commit_sel;
  logic [WIPER_W-1:0] commit_val;
  logic [WIPER_W-1:0] req_val;

  logic               rd_valid_q;
  logic [WIPER_W-1:0] rd_data_q, rd_mux;

  pot_cmd_decode u_decode (
    .valid  (cmd_valid),
    .enable (!recall_q),
    .op     (cmd_op),
    .dec    (dec)
  );

  assign req_val = dec.dr_from_wiper ? wiper_q : cmd_wdata;

  pot_nv_writer #(
    .VAL_W        (WIPER_W),
    .SEL_W        (SEL_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (dec.dr_req),
    .req_sel    (cmd_sel),
    .req_val    (req_val),
    .frame_end  (frame_end),
    .wp_n       (wp_n),
    .wip        (wip_w),
    .commit     (commit),
    .commit_sel (commit_sel),
    .commit_val (commit_val)
  );

  // Persistent cells: deliberately untouched by reset.
  for (genvar g = 0; g < NUM_DR; g++) begin : g_dr
    logic               hit;
    logic [WIPER_W-1:0] cell_q;
    assign hit = commit && (commit_sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (hit) cell_q <= commit_val;
    end
    assign dr_q[g] = cell_q;
  end

  // Wiper next state: recall beats any command.
  always_comb begin
    wiper_en = 1'b0;
    wiper_d  = wiper_q;
    if (recall_q) begin
      wiper_en = 1'b1;
      wiper_d  = dr_q[0];
    end else if (dec.wiper_wr) begin
      wiper_en = 1'b1;
      wiper_d  = cmd_wdata;
    end else if (dec.wiper_load) begin
      wiper_en = 1'b1;
      wiper_d  = dr_q[cmd_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q <= 1'b1;
      wiper_q  <= '0;
    end else begin
      recall_q <= 1'b0;
      if (wiper_en) wiper_q <= wiper_d;
    end
  end

  always_comb begin
    case (dec.rd_src)
      RSRC_WIPER:  rd_mux = wiper_q;
      RSRC_DATA:   rd_mux = dr_q[cmd_sel];
      RSRC_STATUS: rd_mux = WIPER_W'(wip_w);
      default:     rd_mux = rd_data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= dec.rd_en;
      if (dec.rd_en) rd_data_q <= rd_mux;
    end
  end

  pot_tap_decoder #(.CODE_W(WIPER_W)) u_taps (
    .code (wiper_q),
    .tap  (tap_sel)
  );

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign wip      = wip_w;
  assign wiper    = wiper_q;

endmodule

// File: rtl/pot_state_bank_chk.sv
module pot_state_bank_chk #(
  parameter int WIPER_W      = 10,
  parameter int NUM_DR       = 4,
  parameter int WRITE_CYCLES = 500000,
  localparam int TAPS        = 1 << WIPER_W
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cmd_valid,
  input logic [2:0]                     cmd_op,
  input logic                           wp_n,
  input logic                           wip,
  input logic                           rd_valid,
  input logic [WIPER_W-1:0]             wiper,
  input logic [TAPS-1:0]                tap_sel,
  input logic                           recall_q,
  input logic [NUM_DR-1:0][WIPER_W-1:0] dr_q
);

  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (wip) hi_cnt <= hi_cnt + 32'd1;
    else          hi_cnt <= '0;
  end

  // R6: a busy window lasts exactly WRITE_CYCLES cycles
  a_r6_wip_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (hi_cnt == 32'(WRITE_CYCLES)));

  // R6: data registers change only where the busy flag drops
  a_r6_dr_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_q != $past(dr_q)) |-> $fell(wip));

  // R8: a write cannot start while protect was asserted
  a_r8_protect_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wp_n));

  // R3: the wiper holds without a command or a recall
  a_r3_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cmd_valid) && !$past(recall_q)) |-> $stable(wiper));

  // R9: read results come one cycle after a read command
  a_r9_rd_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid));

  a_r9_rd_wiper_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !recall_q && cmd_op == 3'd0) |=> rd_valid);

  // R10: exactly one tap, at the wiper position
  a_r10_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  a_r10_tap_at_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[wiper]);

endmodule

bind pot_state_bank pot_state_bank_chk #(
  .WIPER_W      (WIPER_W),
  .NUM_DR       (NUM_DR),
  .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .wp_n      (wp_n),
  .wip       (wip),
  .rd_valid  (rd_valid),
  .wiper     (wiper),
  .tap_sel   (tap_sel),
  .recall_q  (recall_q),
  .dr_q      (dr_q)
);

// File: tb/pot_state_bank_bench.sv
module pot_state_bank_bench;

  localparam int WW   = 10;
  localparam int NDR  = 4;
  localparam int WCYC = 20;
  localparam int NT   = 1 << WW;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_sel;
  logic [WW-1:0] cmd_wdata;
  logic          frame_end;
  logic          wp_n;
  logic          rd_valid;
  logic [WW-1:0] rd_data;
  logic          wip;
  logic [WW-1:0] wiper;
  logic [NT-1:0] tap_sel;

  pot_state_bank #(.WIPER_W(WW), .NUM_DR(NDR), .WRITE_CYCLES(WCYC)) u_pot_state_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata), .frame_end(frame_end), .wp_n(wp_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .wip(wip), .wiper(wiper), .tap_sel(tap_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  logic [WW-1:0] exp_q[$];
  string         tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries as read results appear.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read result", 32'(rd_data), 32'hFFFF_FFFF);
      end else begin
        check(tag_q.pop_front(), 32'(rd_data), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [1:0] sel, input logic [WW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic rd(input logic [2:0] op, input logic [1:0] sel,
                    input logic [WW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cmd(op, sel, '0);
  endtask

  task automatic frame;
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic wait_idle(input int t0, output int len);
    int guard = 0;
    while (wip && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    len = cyc - t0;
  endtask

  task automatic store(input logic [1:0] sel, input logic [WW-1:0] v);
    int t0, len;
    cmd(3'd3, sel, v);
    check("R5 wip low before frame end", 32'(wip), 32'd0);
    frame;
    t0 = cyc;
    wait_idle(t0, len);
    check("R6 busy window length", 32'(len), 32'(WCYC));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int t0, len;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd7; cmd_sel = '0; cmd_wdata = '0;
    frame_end = 1'b0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 wip in reset", 32'(wip), 32'd0);
    check("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    store(2'd0, 10'h155);
    store(2'd1, 10'h2AA);
    store(2'd2, 10'h3FF);
    store(2'd3, 10'h001);
    rd(3'd2, 2'd0, 10'h155, "R9 read DR0");
    rd(3'd2, 2'd1, 10'h2AA, "R9 read DR1");
    rd(3'd2, 2'd2, 10'h3FF, "R9 read DR2");
    rd(3'd2, 2'd3, 10'h001, "R9 read DR3");
    rd(3'd6, 2'd0, 10'h000, "R9 status idle");

    // Reset again: recall and persistence
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 wip in second reset", 32'(wip), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 recall of DR0", 32'(wiper), 32'h155);
    check("R10 tap at recalled value", 32'(tap_sel[10'h155]), 32'd1);
    rd(3'd0, 2'd0, 10'h155, "R2 wiper read after recall");
    rd(3'd2, 2'd3, 10'h001, "R2 DR3 kept across reset");

    // Wiper writes and tap ends
    cmd(3'd1, 2'd0, 10'h3FF);
    check("R3 wiper write high", 32'(wiper), 32'h3FF);
    check("R10 high end tap", 32'(tap_sel[NT-1]), 32'd1);
    check("R10 single tap", 32'($countones(tap_sel)), 32'd1);
    cmd(3'd1, 2'd0, 10'h000);
    check("R10 low end tap", 32'(tap_sel[0]), 32'd1);
    repeat (3) @(negedge clk);
    check("R3 wiper holds", 32'(wiper), 32'h000);

    // Load wiper from DR1
    cmd(3'd4, 2'd1, 10'h000);
    check("R4 load from DR1", 32'(wiper), 32'h2AA);

    // Store wiper into DR2, deferred until frame end
    cmd(3'd5, 2'd2, 10'h000);
    cmd(3'd1, 2'd0, 10'h010);
    rd(3'd2, 2'd2, 10'h3FF, "R5 DR2 unchanged before frame end");
    check("R5 no busy before frame end", 32'(wip), 32'd0);
    frame;
    t0 = cyc;
    check("R6 busy after frame end", 32'(wip), 32'd1);
    rd(3'd6, 2'd0, 10'h001, "R7 status read while busy");
    rd(3'd2, 2'd2, 10'h3FF, "R6 DR2 old value while busy");
    cmd(3'd1, 2'd0, 10'h020);
    check("R7 wiper write while busy", 32'(wiper), 32'h020);
    cmd(3'd3, 2'd0, 10'h0AA);
    frame;
    wait_idle(t0, len);
    check("R6 store busy length", 32'(len), 32'(WCYC));
    repeat (3) @(negedge clk);
    check("R7 dropped request starts nothing", 32'(wip), 32'd0);
    rd(3'd2, 2'd0, 10'h155, "R7 DR0 unchanged by dropped write");
    rd(3'd2, 2'd2, 10'h2AA, "R6 DR2 holds stored wiper value");

    // Write protect
    @(negedge clk); wp_n = 1'b0;
    cmd(3'd3, 2'd3, 10'h0F0);
    frame;
    check("R8 no busy under protect", 32'(wip), 32'd0);
    cmd(3'd1, 2'd0, 10'h123);
    check("R8 wiper write under protect", 32'(wiper), 32'h123);
    @(negedge clk); wp_n = 1'b1;
    cmd(3'd3, 2'd3, 10'h0F0);
    @(negedge clk); wp_n = 1'b0;
    frame;
    check("R8 protect at frame end blocks start", 32'(wip), 32'd0);
    @(negedge clk); wp_n = 1'b1;
    frame;
    check("R6 frame end discarded pending request", 32'(wip), 32'd0);
    rd(3'd2, 2'd3, 10'h001, "R8 DR3 unchanged");
    store(2'd3, 10'h0F0);
    rd(3'd2, 2'd3, 10'h0F0, "R6 DR3 new value after write");

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule